// File: doc/BRIEF.md
# Single-Wire Configuration Port

This block is the device end of an open-drain, one-wire link that a host controller uses to load two 12-bit configuration words or to send the device back to polling. The host opens a frame by holding the shared line low. After the host lets go, the device supplies the bit clock itself as short low "sync" pulses. For each bit, the host answers inside a sampling window: a host pull-down in the window means 0, and silence means 1. Once a write frame is complete, the device pulls the line low briefly to tell the host that the word it sent was identical to the word already held.

After reset the line carries a reset marker. This is a slow square wave driven by the device, so the host can see that the defaults are loaded. Only a long start pulse opens a frame while the marker runs, and that pulse also stops the marker. All timing is counted in half base-clock units: `tick_i` pulses once per half base period. The line is resynchronised through two flops before any pulse width is measured.

Top module: `swcfg_port`

## Requirements
- R1: After reset, `mode_o` is 12'h12C, `limit_o` is 12'h398, `off_o` is 0, and the line shows the marker. Counting c ticks from reset, the device pulls low exactly when (c mod 8192) >= 4096.
- R2: While the marker runs, a host low pulse opens a frame only if it lasts at least 11265 ticks. Shorter pulses start nothing and leave the marker unchanged.
- R3: Once the marker is gone, the shortest start pulse depends on the rate field `mode_o[11:10]`: 2114, 1066, 542 or 280 ticks for values 0 to 3. A shorter pulse produces no sync pulse.
- R4: The first sync pulse begins 769 ticks after the synchronised line rises. Every sync pulse is 256 ticks of pull-down, and each bit slot lasts 1024 ticks. The device never pulls for two reasons at once.
- R5: A bit reads 0 when the synchronised line is low at any slot count from 383 to 894 (slot count 0 is the first tick of the sync pulse). Otherwise it reads 1. A host low pulse outside that range does not change the bit.
- R6: If the first bit is 1, the frame is an off command. The device emits only that one sync pulse, raises `off_o` for one clock at the end of the slot, and then returns to idle.
- R7: If the first bit is 0, 14 bits are taken. The second bit selects the target (1 = mode word, 0 = limit word), and the next 12 bits form the word, most significant bit first. The target output changes only at the end of the fourteenth slot. The mode word packs rate[11:10], check count[9:8], port[7], sleep[6:2], standard extension[1] and temporary extension[0]. The limit word packs lower limit[11:6] and upper limit[5:0].
- R8: If the received word equals the word the target held before, the device pulls low for 256 ticks, starting at the end of the fourteenth slot. It then stays quiet for the rest of a 516-tick equivalence window.
- R9: A received word that differs from the stored one produces no acknowledge pulse.
- R10: The frame start that is accepted while the marker runs stops the marker for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Half base-clock period enable |
| line_i | input | 1 | Sampled level of the shared line (1 = high) |
| pull_o | output | 1 | Drive the shared line low |
| mode_o | output | 12 | Mode configuration word |
| limit_o | output | 12 | Check-limit configuration word |
| off_o | output | 1 | One-clock strobe for a received off command |

## Verification
The bench holds `tick_i` high and measures every delay in clock edges from the release of the start pulse. Three edges go to resynchronisation and idle detection, so the first sync pulse is due 772 edges after release, and slot k starts 1024·k edges later. An off strobe is due at the first slot boundary. Register changes and any acknowledge pulse are due 14·1024 edges after the first sync pulse. The bench queues these intervals and update times as soon as it releases a start pulse. It then compares `pull_o`, `off_o`, `mode_o` and `limit_o` against that schedule on every falling edge, where no output is changing.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BIT,
    ST_EQV
  } phase_e;

  // Shortest accepted start pulse, in half base-clock ticks, per rate field.
  function automatic int start_min_ht(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2114;
      2'd1:    return 1066;
      2'd2:    return 542;
      default: return 280;
    endcase
  endfunction

endpackage

// File: rtl/swcfg_sync.sv
module swcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swcfg_marker.sv
module swcfg_marker #(
  parameter int HALF = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cancel_i,
  output logic on_o,
  output logic pull_o
);
  localparam int PW = $clog2(2 * HALF);

  logic [PW-1:0] ph_q;
  logic          on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      on_q <= 1'b1;
    end else begin
      if (cancel_i) on_q <= 1'b0;
      if (on_q && tick_i) begin
        if (int'(ph_q) == 2 * HALF - 1) ph_q <= '0;
        else                            ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign on_o   = on_q;
  assign pull_o = on_q && (int'(ph_q) >= HALF);
endmodule

// File: rtl/swcfg_frame.sv
module swcfg_frame
  import swcfg_pkg::*;
#(
  parameter int W        = 12,
  parameter int LEAD_HT  = 769,
  parameter int SYNC_HT  = 256,
  parameter int FRAME_HT = 1024,
  parameter int WIN_LO   = 383,
  parameter int WIN_HI   = 894,
  parameter int EQV_HT   = 516,
  parameter int ACK_HT   = 256,
  parameter int MARK_THR = 11265
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ln_i,
  input  logic         marker_on_i,
  input  logic [1:0]   rate_i,
  input  logic [W-1:0] mode_cur_i,
  input  logic [W-1:0] lim_cur_i,
  output logic         sync_pull_o,
  output logic         ack_pull_o,
  output logic         start_o,
  output logic         off_o,
  output logic         commit_o,
  output logic         commit_sel_o,
  output logic [W-1:0] commit_data_o
);
  localparam int NBITS = W + 2;
  localparam int CW    = $clog2(FRAME_HT + LEAD_HT + EQV_HT);
  localparam int LW    = $clog2(MARK_THR + 1);
  localparam int BW    = $clog2(NBITS);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] low_q;
  logic [BW-1:0] bidx_q;
  logic [W-1:0]  sh_q;
  logic          seen0_q, ack_q, off_q;

  int            thr;
  logic          bit_end, bit_val, is_off, in_win;
  logic [W:0]    rx_word;

  always_comb thr = marker_on_i ? MARK_THR : start_min_ht(rate_i);

  assign start_o       = (ph_q == ST_IDLE) && tick_i && ln_i && (int'(low_q) >= thr);
  assign bit_end       = (ph_q == ST_BIT) && tick_i && (int'(cnt_q) == FRAME_HT - 1);
  assign bit_val       = ~seen0_q;
  assign rx_word       = {sh_q, bit_val};
  assign is_off        = bit_end && (bidx_q == '0) && bit_val;
  assign commit_o      = bit_end && (int'(bidx_q) == NBITS - 1);
  assign commit_sel_o  = rx_word[W];
  assign commit_data_o = rx_word[W-1:0];
  assign in_win        = (int'(cnt_q) >= WIN_LO) && (int'(cnt_q) <= WIN_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= ST_IDLE;
      cnt_q   <= '0;
      low_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      seen0_q <= 1'b0;
      ack_q   <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      off_q <= is_off;
      if (tick_i) begin
        unique case (ph_q)
          ST_IDLE: begin
            if (start_o) begin
              ph_q  <= ST_LEAD;
              cnt_q <= '0;
              low_q <= '0;
            end else if (!ln_i) begin
              if (low_q != '1) low_q <= low_q + 1'b1;
            end else begin
              low_q <= '0;
            end
          end
          ST_LEAD: begin
            if (int'(cnt_q) == LEAD_HT - 1) begin
              ph_q    <= ST_BIT;
              cnt_q   <= '0;
              bidx_q  <= '0;
              seen0_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BIT: begin
            if (bit_end) begin
              sh_q    <= rx_word[W-1:0];
              seen0_q <= 1'b0;
              cnt_q   <= '0;
              if (is_off) begin
                ph_q <= ST_IDLE;
              end else if (commit_o) begin
                ph_q  <= ST_EQV;
                ack_q <= (commit_sel_o ? mode_cur_i : lim_cur_i) == commit_data_o;
              end else begin
                bidx_q <= bidx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (in_win && !ln_i) seen0_q <= 1'b1;
            end
          end
          ST_EQV: begin
            if (int'(cnt_q) == EQV_HT - 1) begin
              ph_q  <= ST_IDLE;
              cnt_q <= '0;
              low_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign sync_pull_o = (ph_q == ST_BIT) && (int'(cnt_q) < SYNC_HT);
  assign ack_pull_o  = (ph_q == ST_EQV) && ack_q && (int'(cnt_q) < ACK_HT);
  assign off_o       = off_q;
endmodule

// File: rtl/swcfg_port.sv
module swcfg_port #(
  parameter int          W         = 12,
  parameter logic [11:0] MODE_RST  = 12'h12C,
  parameter logic [11:0] LIMIT_RST = 12'h398,
  parameter int          MARK_HALF = 4096,
  parameter int          MARK_THR  = 11265
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         line_i,
  output logic         pull_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] limit_o,
  output logic         off_o
);
  localparam int RATE_LSB = W - 2;

  logic         ln, marker_on, marker_pull, sync_pull, ack_pull, start;
  logic         commit, commit_sel;
  logic [W-1:0] commit_data, mode_q, lim_q;

  swcfg_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(ln)
  );

  swcfg_marker #(.HALF(MARK_HALF)) u_marker (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cancel_i(start),
    .on_o(marker_on), .pull_o(marker_pull)
  );

  swcfg_frame #(.W(W), .MARK_THR(MARK_THR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ln_i(ln),
    .marker_on_i(marker_on), .rate_i(mode_q[RATE_LSB +: 2]),
    .mode_cur_i(mode_q), .lim_cur_i(lim_q),
    .sync_pull_o(sync_pull), .ack_pull_o(ack_pull), .start_o(start),
    .off_o(off_o), .commit_o(commit), .commit_sel_o(commit_sel),
    .commit_data_o(commit_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST[W-1:0];
      lim_q  <= LIMIT_RST[W-1:0];
    end else if (commit) begin
      if (commit_sel) mode_q <= commit_data;
      else            lim_q  <= commit_data;
    end
  end

  assign pull_o  = marker_pull | sync_pull | ack_pull;
  assign mode_o  = mode_q;
  assign limit_o = lim_q;
endmodule

// File: rtl/swcfg_port_chk.sv
module swcfg_port_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         off_o,
  input logic         marker_on,
  input logic         marker_pull,
  input logic         sync_pull,
  input logic         ack_pull,
  input logic         start,
  input logic         commit,
  input logic [W-1:0] mode_o,
  input logic [W-1:0] limit_o
);
  assert_one_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({marker_pull, sync_pull, ack_pull}));

  assert_off_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o |=> !off_o);

  assert_regs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(mode_o) && $stable(limit_o)));

  assert_ack_follows_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_pull) |-> $past(commit));

  assert_start_stops_marker_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !marker_on);

  assert_marker_stays_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !marker_on |=> !marker_on);
endmodule

bind swcfg_port swcfg_port_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .off_o(off_o), .marker_on(marker_on),
  .marker_pull(marker_pull), .sync_pull(sync_pull), .ack_pull(ack_pull),
  .start(start), .commit(commit), .mode_o(mode_o), .limit_o(limit_o)
);

// File: tb/swcfg_port_tb_top.sv
module swcfg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_low = 1'b0;
  logic        line, pull, off;
  logic [11:0] mode, limit;

  always #2 clk = ~clk;

  assign line = ~(pull | host_low);

  swcfg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .line_i(line),
    .pull_o(pull), .mode_o(mode), .limit_o(limit), .off_o(off)
  );

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int checks = 0, errors = 0;
  int r0 = 0;
  int mark_cancel = 32'h7fffffff;
  bit chk_en = 1'b0;
  string cur_req = "R1";

  int iv_lo[$], iv_hi[$], off_pe[$], upd_pe[$];
  logic upd_sel[$];
  logic [11:0] upd_val[$];
  logic [11:0] exp_mode = 12'h12C, exp_lim = 12'h398;
  logic [11:0] sh_mode = 12'h12C, sh_lim = 12'h398;

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    if (errors < 30)
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, pe, act, expv);
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      bit ep, eo;
      while (upd_pe.size() > 0 && upd_pe[0] <= pe) begin
        if (upd_sel[0]) exp_mode = upd_val[0];
        else            exp_lim  = upd_val[0];
        void'(upd_pe.pop_front()); void'(upd_sel.pop_front()); void'(upd_val.pop_front());
      end
      ep = (pe < mark_cancel) && (((pe - r0) % 8192) >= 4096);
      foreach (iv_lo[i]) if (pe >= iv_lo[i] && pe < iv_hi[i]) ep = 1'b1;
      eo = 1'b0;
      foreach (off_pe[i]) if (off_pe[i] == pe) eo = 1'b1;
      checks += 4;
      if (pull !== ep)       fail(cur_req, "pull_o (R4 timing)", pull, ep);
      if (off !== eo)        fail(cur_req, "off_o (R6)", off, eo);
      if (mode !== exp_mode) fail(cur_req, "mode_o (R7)", mode, exp_mode);
      if (limit !== exp_lim) fail(cur_req, "limit_o (R7)", limit, exp_lim);
    end
  end

  task automatic wait_to(input int p);
    while (pe < p) @(negedge clk);
  endtask

  task automatic host_pulse(input int dur, output int rel);
    host_low = 1'b1;
    repeat (dur) @(negedge clk);
    host_low = 1'b0;
    rel = pe;
  endtask

  task automatic ignored_pulse(input int dur);
    int p;
    host_pulse(dur, p);
    wait_to(p + 1500);
  endtask

  // w[13] is sent first; nb = 1 for an off command, 14 for a write
  task automatic send_frame(input logic [13:0] w, input int nb, input int dur, input int ow_k);
    int p, t0, te;
    logic sel, ack;
    logic [11:0] d;
    host_pulse(dur, p);
    if (mark_cancel > p + 3) mark_cancel = p + 3;
    t0 = p + 772;
    for (int k = 0; k < nb; k++) begin
      iv_lo.push_back(t0 + 1024 * k);
      iv_hi.push_back(t0 + 1024 * k + 256);
    end
    if (nb == 1) begin
      off_pe.push_back(t0 + 1024);
    end else begin
      sel = w[12];
      d   = w[11:0];
      ack = sel ? (sh_mode == d) : (sh_lim == d);
      te  = t0 + 14 * 1024;
      if (ack) begin
        iv_lo.push_back(te);
        iv_hi.push_back(te + 256);
      end
      upd_pe.push_back(te); upd_sel.push_back(sel); upd_val.push_back(d);
      if (sel) sh_mode = d; else sh_lim = d;
    end
    for (int k = 0; k < nb; k++) begin
      if (w[13 - k] == 1'b0) begin
        wait_to(t0 + 1024 * k + 500); host_low = 1'b1;
        wait_to(t0 + 1024 * k + 700); host_low = 1'b0;
      end else if (k == ow_k) begin
        wait_to(t0 + 1024 * k + 950); host_low = 1'b1;
        wait_to(t0 + 1024 * k + 990); host_low = 1'b0;
      end
    end
    if (nb == 1) wait_to(t0 + 1034);
    else         wait_to(t0 + 14 * 1024 + 526);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    r0 = pe;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (mode !== 12'h12C || limit !== 12'h398 || off !== 1'b0 || pull !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: mode %0h limit %0h off %0b pull %0b expected 12c 398 0 0",
               mode, limit, off, pull);
    end
    chk_en = 1'b1;

    cur_req = "R2";   // short pulse during marker is ignored
    wait_to(r0 + 200);
    ignored_pulse(3000);

    cur_req = "R10";  // long start pulse cancels marker; equal mode word -> R8 ack
    wait_to(r0 + 8300);
    send_frame({1'b0, 1'b1, 12'h12C}, 14, 11300, -1);

    cur_req = "R3";   // rate 0: 2113 ignored, 2114 accepted; R9 no ack on differing limit
    ignored_pulse(2113);
    send_frame({1'b0, 1'b0, 12'h2A5}, 14, 2114, -1);

    cur_req = "R7";   // write mode with rate 3
    send_frame({1'b0, 1'b1, 12'hC55}, 14, 2200, -1);

    cur_req = "R6";   // rate 3: 279 ignored, 280 opens an off command
    ignored_pulse(279);
    send_frame(14'h2000, 1, 280, -1);

    cur_req = "R5";   // equal limit word with an out-of-window pulse on a 1 bit -> R8 ack
    send_frame({1'b0, 1'b0, 12'h2A5}, 14, 300, 13);

    repeat (50) @(negedge clk);
    checks++;
    if (mode !== 12'hC55) begin
      errors++;
      $display("FAIL R7 final mode: actual %0h expected c55", mode);
    end
    checks++;
    if (limit !== 12'h2A5) begin
      errors++;
      $display("FAIL R7 final limit: actual %0h expected 2a5", limit);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule